// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block is a small data cache that sits between a processor load/store port and a main-memory port that moves one 32-bit word at a time. Each byte address is split into a line offset, a line index and a tag. One lookup checks the indexed line's valid bit and stored tag. A hit is answered in the same cycle. A miss stalls the processor while the whole line is brought in from memory.

A build-time parameter picks how stores are handled. With `WRITE_BACK=1`, stores stay in the cache and mark the line dirty. A dirty line is copied out to memory before its slot is refilled. A store miss first loads the line and then merges the store into it. With `WRITE_BACK=0`, every store goes to memory as a single word beat and updates the cache only when the line is present. A store miss leaves the cache as it was, while a later load miss to that line still brings the line in.

The processor holds `cpu_req_i` and its request fields until it sees `cpu_ready_o` high. The memory side holds `mem_valid_o` and its request fields until `mem_ready_i` is high. For a read beat, `mem_rdata_i` is taken in the same cycle as the handshake.

Top module: `dm_cache`

## Requirements
- R1: Address bits [5:0] are the byte offset, bits [7:6] select one of 4 lines, and bits [31:8] are the tag. Lines with different index values are held at the same time. Two addresses with the same index and different tags displace each other.
- R2: After reset every line is invalid, so the first access misses even when its tag is zero. With no request pending, `cpu_ready_o` and `mem_valid_o` are low.
- R3: A load hit raises `cpu_ready_o` in the cycle it is presented and returns the addressed word on `cpu_rdata_o`. `cpu_ready_o` is never high without `cpu_req_i`.
- R4: A load miss reads the 16 words of the line in increasing word order, starting at the line base address. `cpu_ready_o` stays low until the line is installed. The miss then completes as a hit, so a clean miss with a memory that is always ready takes 18 cycles. A memory request is held stable until it is accepted.
- R5: In write-back mode, a store hit finishes in one cycle, changes only the cached line and produces no memory write beat.
- R6: In write-back mode, a miss whose victim line is valid and dirty first writes the victim's 16 words (byte enables 4'hf) in increasing order, then refills the line. With a memory that is always ready this takes 34 cycles, and memory afterwards holds the stored data.
- R7: In write-back mode, a clean victim is overwritten without any memory write beat.
- R8: In write-back mode, a store miss fetches the line, merges the store and produces no memory write. The line then hits.
- R9: In write-through mode, every store hit makes exactly one memory write beat carrying the store's data and byte enables. It also updates the cached word, which the next load returns in one cycle.
- R10: In write-through mode, a store miss makes one memory write beat and changes no line. The line that was already at that index still hits, and the stored line still misses.
- R11: In write-through mode, a load miss installs the line, including a line that was last touched by a store miss.
- R12: Byte-enable bit i selects data bits [8i+7:8i]. Bytes whose enable is low keep their previous value, both in the cache and in memory.
- R13: Under any mix of loads and stores, with a memory that sometimes stalls, a load returns the most recently stored value of each byte. In write-through mode, memory also matches that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Store data |
| cpu_be_i | input | 4 | Store byte enables |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | 32 | Load data, valid with ready |
| mem_valid_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr_o | output | 32 | Word-aligned beat address |
| mem_wdata_o | output | 32 | Write beat data |
| mem_be_o | output | 4 | Write beat byte enables |
| mem_ready_i | input | 1 | Memory accepts the beat this cycle |
| mem_rdata_i | input | 32 | Read beat data, valid with ready |

## Verification
The bench builds two copies of the default geometry (4 lines of 64 bytes) side by side, one with `WRITE_BACK=1` and one with `WRITE_BACK=0`, and drives them one after the other. This covers dirty eviction and write-allocate merging as well as store-around behaviour in the same run. All traffic is kept inside a 4 KB window, so 16 tags compete for each index. As a result, conflict misses, dirty victims and repeated refills of a line come up often under random traffic. Directed steps use a memory that is always ready, so that the exact miss latencies can be checked. The random phases stall the memory at random to exercise the request-hold rule.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned BE_W   = WORD_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2
  } ctrl_state_e;

  function automatic logic [WORD_W-1:0] merge_bytes(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w,
    input logic [BE_W-1:0]   be
  );
    logic [WORD_W-1:0] res;
    res = old_w;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) res[8*b +: 8] = new_w[8*b +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/dm_cache_tag_store.sv
module dm_cache_tag_store #(
  parameter int unsigned TAG_W      = 24,
  parameter int unsigned NUM_LINES  = 4,
  parameter bit          WRITE_BACK = 1'b1,
  localparam int unsigned IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             install_i,
  input  logic             mark_dirty_i,
  output logic             hit_o,
  output logic             vic_valid_o,
  output logic             vic_dirty_o,
  output logic [TAG_W-1:0] vic_tag_o
);

  logic [NUM_LINES-1:0] valid_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];
  logic [NUM_LINES-1:0] dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        valid_q <= '0;
    else if (install_i) valid_q[idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (install_i) tag_q[idx_i] <= tag_i;
  end

  generate
    if (WRITE_BACK) begin : g_dirty
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           dirty_q <= '0;
        else if (install_i)    dirty_q[idx_i] <= 1'b0;
        else if (mark_dirty_i) dirty_q[idx_i] <= 1'b1;
      end
    end else begin : g_no_dirty
      logic unused_mark;
      assign unused_mark = mark_dirty_i;
      assign dirty_q     = '0;
    end
  endgenerate

  assign vic_valid_o = valid_q[idx_i];
  assign vic_dirty_o = dirty_q[idx_i];
  assign vic_tag_o   = tag_q[idx_i];
  assign hit_o       = valid_q[idx_i] && (tag_q[idx_i] == tag_i);

endmodule

// File: rtl/dm_cache_line_ram.sv
module dm_cache_line_ram #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned WORDS     = 16,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES),
  localparam int unsigned WSEL_W   = $clog2(WORDS),
  localparam int unsigned DEPTH    = NUM_LINES * WORDS
) (
  input  logic                                clk_i,
  input  logic [IDX_W-1:0]                    idx_i,
  input  logic                                we_i,
  input  logic [WSEL_W-1:0]                   wsel_i,
  input  logic [dm_cache_pkg::WORD_W-1:0]     wdata_i,
  input  logic [dm_cache_pkg::BE_W-1:0]       wbe_i,
  input  logic [WSEL_W-1:0]                   rsel_i,
  output logic [dm_cache_pkg::WORD_W-1:0]     rdata_o
);
  import dm_cache_pkg::*;

  logic [WORD_W-1:0] ram_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wbe_i[b]) ram_q[{idx_i, wsel_i}][8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end

  assign rdata_o = ram_q[{idx_i, rsel_i}];

endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl #(
  parameter int unsigned WORDS      = 16,
  parameter bit          WRITE_BACK = 1'b1,
  localparam int unsigned WSEL_W    = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic              hit_i,
  input  logic              vic_valid_i,
  input  logic              vic_dirty_i,
  input  logic              mem_ready_i,
  output logic              cpu_ready_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic              evicting_o,
  output logic              line_xfer_o,
  output logic [WSEL_W-1:0] beat_o,
  output logic              fill_wr_o,
  output logic              install_o,
  output logic              store_upd_o,
  output logic              mark_dirty_o
);
  import dm_cache_pkg::*;

  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

  ctrl_state_e       state_q, state_d;
  logic [WSEL_W-1:0] beat_q, beat_d;
  logic              wt_store;

  assign wt_store = !WRITE_BACK && cpu_we_i;

  always_comb begin
    state_d      = state_q;
    beat_d       = beat_q;
    cpu_ready_o  = 1'b0;
    mem_valid_o  = 1'b0;
    mem_we_o     = 1'b0;
    fill_wr_o    = 1'b0;
    install_o    = 1'b0;
    store_upd_o  = 1'b0;
    mark_dirty_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req_i) begin
          if (wt_store) begin
            // store goes straight to memory; cache updated only on hit
            mem_valid_o = 1'b1;
            mem_we_o    = 1'b1;
            cpu_ready_o = mem_ready_i;
            store_upd_o = mem_ready_i && hit_i;
          end else if (hit_i) begin
            cpu_ready_o  = 1'b1;
            store_upd_o  = cpu_we_i;
            mark_dirty_o = cpu_we_i;
          end else begin
            beat_d  = '0;
            state_d = (WRITE_BACK && vic_valid_i && vic_dirty_i) ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        mem_valid_o = 1'b1;
        mem_we_o    = 1'b1;
        if (mem_ready_i) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_valid_o = 1'b1;
        if (mem_ready_i) begin
          fill_wr_o = 1'b1;
          beat_d    = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            install_o = 1'b1;
            state_d   = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign evicting_o  = (state_q == ST_EVICT);
  assign line_xfer_o = (state_q == ST_EVICT) || (state_q == ST_FILL);
  assign beat_o      = beat_q;

endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned NUM_LINES  = 4,
  parameter bit          WRITE_BACK = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cpu_req_i,
  input  logic        cpu_we_i,
  input  logic [31:0] cpu_addr_i,
  input  logic [31:0] cpu_wdata_i,
  input  logic [3:0]  cpu_be_i,
  output logic        cpu_ready_o,
  output logic [31:0] cpu_rdata_o,
  output logic        mem_valid_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic [3:0]  mem_be_o,
  input  logic        mem_ready_i,
  input  logic [31:0] mem_rdata_i
);
  import dm_cache_pkg::*;

  localparam int unsigned WORDS  = LINE_BYTES / BE_W;
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W  = $clog2(NUM_LINES);
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int unsigned WSEL_W = $clog2(WORDS);
  localparam int unsigned BSEL_W = $clog2(BE_W);

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] cpu_wsel;
  logic [BSEL_W-1:0] unused_addr_bits;

  assign idx              = cpu_addr_i[OFF_W +: IDX_W];
  assign tag              = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign cpu_wsel         = cpu_addr_i[BSEL_W +: WSEL_W];
  assign unused_addr_bits = cpu_addr_i[BSEL_W-1:0];

  logic              hit, vic_valid, vic_dirty;
  logic [TAG_W-1:0]  vic_tag;
  logic              evicting, line_xfer, fill_wr, install, store_upd, mark_dirty;
  logic [WSEL_W-1:0] beat;
  logic [WORD_W-1:0] ram_rdata;

  dm_cache_tag_store #(
    .TAG_W(TAG_W), .NUM_LINES(NUM_LINES), .WRITE_BACK(WRITE_BACK)
  ) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (idx),
    .tag_i       (tag),
    .install_i   (install),
    .mark_dirty_i(mark_dirty),
    .hit_o       (hit),
    .vic_valid_o (vic_valid),
    .vic_dirty_o (vic_dirty),
    .vic_tag_o   (vic_tag)
  );

  dm_cache_line_ram #(
    .NUM_LINES(NUM_LINES), .WORDS(WORDS)
  ) u_ram (
    .clk_i  (clk_i),
    .idx_i  (idx),
    .we_i   (fill_wr || store_upd),
    .wsel_i (fill_wr ? beat : cpu_wsel),
    .wdata_i(fill_wr ? mem_rdata_i : cpu_wdata_i),
    .wbe_i  (fill_wr ? {BE_W{1'b1}} : cpu_be_i),
    .rsel_i (evicting ? beat : cpu_wsel),
    .rdata_o(ram_rdata)
  );

  dm_cache_ctrl #(
    .WORDS(WORDS), .WRITE_BACK(WRITE_BACK)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .hit_i       (hit),
    .vic_valid_i (vic_valid),
    .vic_dirty_i (vic_dirty),
    .mem_ready_i (mem_ready_i),
    .cpu_ready_o (cpu_ready_o),
    .mem_valid_o (mem_valid_o),
    .mem_we_o    (mem_we_o),
    .evicting_o  (evicting),
    .line_xfer_o (line_xfer),
    .beat_o      (beat),
    .fill_wr_o   (fill_wr),
    .install_o   (install),
    .store_upd_o (store_upd),
    .mark_dirty_o(mark_dirty)
  );

  assign mem_addr_o  = {(evicting ? vic_tag : tag), idx,
                        (line_xfer ? beat : cpu_wsel), {BSEL_W{1'b0}}};
  assign mem_wdata_o = evicting ? ram_rdata : cpu_wdata_i;
  assign mem_be_o    = (mem_we_o && !evicting) ? cpu_be_i : {BE_W{1'b1}};
  assign cpu_rdata_o = ram_rdata;

endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter bit          WRITE_BACK = 1'b1,
  localparam int unsigned WSEL_W    = $clog2(LINE_BYTES / 4)
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cpu_req_i,
  input logic        cpu_we_i,
  input logic [3:0]  cpu_be_i,
  input logic        cpu_ready_o,
  input logic        mem_valid_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [3:0]  mem_be_o,
  input logic        mem_ready_i
);

  logic last_word;
  assign last_word = (mem_addr_o[2 +: WSEL_W] == {WSEL_W{1'b1}});

  // R3
  ready_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> cpu_req_i);

  // R4
  mem_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R4
  burst_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_ready_i && !last_word && (WRITE_BACK || !mem_we_o)) |=>
      (!mem_valid_o || mem_addr_o == $past(mem_addr_o) + 32'd4));

  generate
    if (WRITE_BACK) begin : g_wb
      // R5
      wb_no_store_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_valid_o && mem_we_o) |-> (!cpu_ready_o && mem_be_o == 4'hf));
      // R6
      refill_after_evict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_valid_o && mem_ready_i && mem_we_o && last_word) |=>
          (mem_valid_o && !mem_we_o));
    end else begin : g_wt
      // R9
      wt_store_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_valid_o && mem_we_o) |->
          (cpu_req_i && cpu_we_i && mem_be_o == cpu_be_i));
    end
  endgenerate

endmodule

bind dm_cache dm_cache_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WRITE_BACK(WRITE_BACK)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_req_i  (cpu_req_i),
  .cpu_we_i   (cpu_we_i),
  .cpu_be_i   (cpu_be_i),
  .cpu_ready_o(cpu_ready_o),
  .mem_valid_o(mem_valid_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_be_o   (mem_be_o),
  .mem_ready_i(mem_ready_i)
);

// File: tb/dm_cache_tb.sv
`timescale 1ns/1ps
module dm_cache_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;          // 0: write-back copy, 1: write-through copy
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        mem_ready = 1'b1;
  logic        stall_en = 1'b0;

  logic        rdy_a, rdy_b, mv_a, mv_b, mwe_a, mwe_b;
  logic [31:0] rd_a, rd_b, ma_a, ma_b, mwd_a, mwd_b;
  logic [3:0]  mbe_a, mbe_b;
  logic [31:0] mem_rdata;

  logic        cpu_ready, mem_valid, mem_we;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata;
  logic [3:0]  mem_be;

  always #2 clk = ~clk;

  dm_cache #(.WRITE_BACK(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req && !sel), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_be_i(cpu_be),
    .cpu_ready_o(rdy_a), .cpu_rdata_o(rd_a), .mem_valid_o(mv_a), .mem_we_o(mwe_a),
    .mem_addr_o(ma_a), .mem_wdata_o(mwd_a), .mem_be_o(mbe_a),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata));

  dm_cache #(.WRITE_BACK(1'b0)) u_dut_wt (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req && sel), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_be_i(cpu_be),
    .cpu_ready_o(rdy_b), .cpu_rdata_o(rd_b), .mem_valid_o(mv_b), .mem_we_o(mwe_b),
    .mem_addr_o(ma_b), .mem_wdata_o(mwd_b), .mem_be_o(mbe_b),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata));

  assign cpu_ready = sel ? rdy_b : rdy_a;
  assign cpu_rdata = sel ? rd_b  : rd_a;
  assign mem_valid = sel ? mv_b  : mv_a;
  assign mem_we    = sel ? mwe_b : mwe_a;
  assign mem_addr  = sel ? ma_b  : ma_a;
  assign mem_wdata = sel ? mwd_b : mwd_a;
  assign mem_be    = sel ? mbe_b : mbe_a;

  logic [31:0] mem     [1024];
  logic [31:0] ref_mem [1024];
  int          n_chk = 0, n_fail = 0, n_wr = 0, order_err = 0;
  logic [3:0]  beat_idx = '0;

  assign mem_rdata = mem[mem_addr[11:2]];

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] init_val(input int i);
    return (32'(i) * 32'h0100_0193) ^ 32'hA5C3_0000;
  endfunction

  // memory model and burst order monitor
  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        n_wr++;
        mem[mem_addr[11:2]] = merge(mem[mem_addr[11:2]], mem_wdata, mem_be);
      end
      if (!sel || !mem_we) begin
        if (mem_addr[5:2] != beat_idx) order_err++;
        beat_idx = beat_idx + 4'd1;
      end
    end
  end

  always @(negedge clk) mem_ready <= stall_en ? (($urandom % 4) != 0) : 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    cyc = 0;
    forever begin
      #1;
      cyc++;
      if (cpu_ready) begin
        rd = cpu_rdata;
        break;
      end
      @(negedge clk);
    end
    @(posedge clk);
    #1 cpu_req = 1'b0;
    if (we) ref_mem[a[11:2]] = merge(ref_mem[a[11:2]], wd, be);
  endtask

  task automatic phase_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; cpu_req = 1'b0; sel = mode; stall_en = 1'b0;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = init_val(i);
      ref_mem[i] = init_val(i);
    end
    beat_idx = '0; order_err = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(cpu_ready == 1'b0, "R2", "ready after reset", 32'(cpu_ready), 32'd0);
    check(mem_valid == 1'b0, "R2", "mem_valid after reset", 32'(mem_valid), 32'd0);
  endtask

  task automatic load_chk(input logic [31:0] a, input int exp_cyc, input string req);
    logic [31:0] rd;
    int cyc;
    access(1'b0, a, '0, '0, rd, cyc);
    check(rd == ref_mem[a[11:2]], req, "load data", rd, ref_mem[a[11:2]]);
    if (exp_cyc > 0) check(cyc == exp_cyc, req, "load latency", 32'(cyc), 32'(exp_cyc));
  endtask

  task automatic random_run(input int n);
    logic [31:0] rd, a;
    int cyc;
    bit we;
    stall_en = 1'b1;
    for (int k = 0; k < n; k++) begin
      a  = 32'($urandom % 1024) << 2;
      we = ($urandom % 2) == 1;
      if (we) access(1'b1, a, $urandom, 4'($urandom), rd, cyc);
      else begin
        access(1'b0, a, '0, '0, rd, cyc);
        check(rd == ref_mem[a[11:2]], "R13", "random load", rd, ref_mem[a[11:2]]);
      end
    end
    stall_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc, w0, mism;
    void'($urandom(32'd1234));

    // ---------------- write-back copy ----------------
    phase_reset(1'b0);
    load_chk(32'h000, 18, "R2");                  // tag 0 still misses
    check(order_err == 0, "R4", "fill word order", 32'(order_err), 0);
    load_chk(32'h004, 1, "R3");
    load_chk(32'h040, 18, "R4");
    load_chk(32'h008, 1, "R1");                   // index 0 and 1 coexist
    w0 = n_wr;
    access(1'b1, 32'h010, 32'hDEAD_BEEF, 4'b0101, rd, cyc);
    check(cyc == 1, "R5", "store hit latency", 32'(cyc), 1);
    check(n_wr == w0, "R5", "store hit write beats", 32'(n_wr - w0), 0);
    check(mem[4] == init_val(4), "R5", "memory untouched", mem[4], init_val(4));
    load_chk(32'h010, 1, "R12");                  // merged bytes only
    w0 = n_wr;
    load_chk(32'h100, 34, "R6");                  // dirty victim tag 0
    check(n_wr - w0 == 16, "R6", "evict beats", 32'(n_wr - w0), 16);
    check(mem[4] == ref_mem[4], "R6", "written back word", mem[4], ref_mem[4]);
    check(order_err == 0, "R6", "evict word order", 32'(order_err), 0);
    w0 = n_wr;
    load_chk(32'h010, 18, "R7");                  // clean victim tag 1
    check(n_wr == w0, "R7", "clean victim beats", 32'(n_wr - w0), 0);
    w0 = n_wr;
    access(1'b1, 32'h280, 32'h1234_5678, 4'b1100, rd, cyc);
    check(cyc == 18, "R8", "store miss latency", 32'(cyc), 18);
    check(n_wr == w0, "R8", "store miss write beats", 32'(n_wr - w0), 0);
    load_chk(32'h284, 1, "R8");
    load_chk(32'h280, 1, "R8");
    load_chk(32'h000, 1, "R1");
    load_chk(32'h100, 18, "R1");                  // same index, other tag
    load_chk(32'h000, 18, "R1");
    random_run(300);
    check(order_err == 0, "R4", "burst order under stalls", 32'(order_err), 0);

    // ---------------- write-through copy ----------------
    phase_reset(1'b1);
    load_chk(32'h000, 18, "R11");
    w0 = n_wr;
    access(1'b1, 32'h004, 32'hCAFE_F00D, 4'hf, rd, cyc);
    check(cyc == 1, "R9", "store hit latency", 32'(cyc), 1);
    check(n_wr - w0 == 1, "R9", "store hit beats", 32'(n_wr - w0), 1);
    check(mem[1] == 32'hCAFE_F00D, "R9", "memory updated", mem[1], 32'hCAFE_F00D);
    load_chk(32'h004, 1, "R9");
    w0 = n_wr;
    access(1'b1, 32'h104, 32'h0BAD_CAFE, 4'hf, rd, cyc);
    check(n_wr - w0 == 1, "R10", "store miss beats", 32'(n_wr - w0), 1);
    check(mem[32'h41] == 32'h0BAD_CAFE, "R10", "memory updated", mem[32'h41], 32'h0BAD_CAFE);
    load_chk(32'h008, 1, "R10");                  // old line kept
    load_chk(32'h104, 18, "R10");                 // not allocated by store
    load_chk(32'h108, 1, "R11");
    access(1'b1, 32'h10C, 32'hFFFF_FFFF, 4'b0010, rd, cyc);
    check(mem[32'h43] == ref_mem[32'h43], "R12", "memory byte merge", mem[32'h43], ref_mem[32'h43]);
    load_chk(32'h10C, 1, "R12");
    random_run(300);
    mism = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] != ref_mem[i]) mism++;
    check(mism == 0, "R13", "memory matches stores", 32'(mism), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule